// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit works out where a 32-bit processor fetches next after each instruction. Each cycle it takes the current program counter, the instruction word and the two register operand values that the register file read for the instruction's first and second source fields. It decides whether control moves, computes the target, and produces a write request for the return-address register when the instruction is a call. It also raises single-cycle indications for exception return, breakpoint return, breakpoint trap and system call, so that exception logic elsewhere can act on them.

All results are registered. The outputs for an instruction presented before a rising clock edge are visible right after that edge. A synchronous active-low reset clears every registered output.

Top module: `bnpc_unit`

## Requirements
- R1: Conditional branches use opcode bits 31:26: 17 branches when equal, 23 when not equal, 18 when greater (signed), 19 when greater-or-equal (signed), 21 when greater (unsigned) and 20 when greater-or-equal (unsigned). Operand A (register field 25:21) is compared with operand B (register field 20:16). When the condition holds, `taken` is 1 and `next_pc` is PC plus the 16-bit field 15:0 shifted left by two and sign-extended from bit 17.
- R2: A conditional branch whose condition is false gives `taken` = 0 and `next_pc` = PC + 4.
- R3: Opcode 56 is a relative jump. `taken` is 1 and `next_pc` is PC plus field 25:0 shifted left by two and sign-extended from bit 27. No link write is made.
- R4: Opcode 62 is a relative call. It has the same target as R3, and `link_we` = 1 with `link_data` = PC + 4.
- R5: Opcode 48 jumps to operand A: `taken` = 1, `next_pc` = operand A, no link write.
- R6: Opcode 54 jumps to operand A and also requests `link_data` = PC + 4 with `link_we` = 1.
- R7: With opcode 48, register field 25:21 equal to 30 sets `eret_flag`, and 31 sets `bret_flag`. Field value 29 (plain return) and any other value set neither flag. The jump of R5 takes place in every case.
- R8: Opcode 43 with field 25:0 equal to 2 sets `brk_flag`, and equal to 7 sets `scall_flag`. Any other value sets no flag. In all these cases `taken` = 0 and `next_pc` = PC + 4.
- R9: Any opcode other than those above gives `taken` = 0, `next_pc` = PC + 4, `link_we` = 0 and all four flags at 0.
- R10: `link_idx` is always 29. When `link_we` is 0, `link_data` is 0. At most one of the four flags is set in any cycle.
- R11: Outputs update one clock edge after the inputs are sampled. A clock edge with `rst_n` low sets `next_pc`, `link_data`, `taken`, `link_we` and all flags to 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_pc | input | 32 | Address of the instruction being resolved |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of the register named by bits 25:21 |
| opnd_b | input | 32 | Value of the register named by bits 20:16 |
| next_pc | output | 32 | Fetch address that follows the instruction |
| taken | output | 1 | Control moved away from PC + 4 |
| link_we | output | 1 | Write request for the return-address register |
| link_idx | output | 5 | Index of the return-address register (29) |
| link_data | output | 32 | Return address to write |
| eret_flag | output | 1 | Exception return seen |
| bret_flag | output | 1 | Breakpoint return seen |
| brk_flag | output | 1 | Breakpoint trap seen |
| scall_flag | output | 1 | System call seen |

## Verification
Each branch condition is driven with operand pairs that are equal, that differ only in sign interpretation (all-ones against one), and that are ordered both ways. These pairs separate the signed comparisons from the unsigned ones and the strict comparisons from the inclusive ones. Offsets are tried positive, at minus one word and at the most negative value of each field, to show the sign extension from bits 17 and 27. The register-jump opcode is tried with register fields 29, 30, 31 and an ordinary register to separate the two return flags from a plain return. The trap opcode is tried with codes 2, 7 and an unassigned code to show that only the two defined codes raise a flag.

// File: rtl/bnpc_pkg.sv
// Package: shared opcode codes, transfer classes and decoded-control record
// for the branch and next-PC unit. Assumes a 6-bit major opcode in bits 31:26.
package bnpc_pkg;

    localparam int OPC_W     = 6;
    localparam int RIDX_W    = 5;

    // Major opcodes that the unit recognises
    localparam logic [OPC_W-1:0] OPC_BR_EQ    = 6'd17;
    localparam logic [OPC_W-1:0] OPC_BR_GTS   = 6'd18;
    localparam logic [OPC_W-1:0] OPC_BR_GES   = 6'd19;
    localparam logic [OPC_W-1:0] OPC_BR_GEU   = 6'd20;
    localparam logic [OPC_W-1:0] OPC_BR_GTU   = 6'd21;
    localparam logic [OPC_W-1:0] OPC_BR_NE    = 6'd23;
    localparam logic [OPC_W-1:0] OPC_JMP_REG  = 6'd48;
    localparam logic [OPC_W-1:0] OPC_CALL_REG = 6'd54;
    localparam logic [OPC_W-1:0] OPC_JMP_REL  = 6'd56;
    localparam logic [OPC_W-1:0] OPC_CALL_REL = 6'd62;
    localparam logic [OPC_W-1:0] OPC_TRAP     = 6'd43;

    // Class of control transfer an instruction performs
    typedef enum logic [2:0] {
        XF_NONE = 3'd0,
        XF_COND = 3'd1,
        XF_REL  = 3'd2,
        XF_REG  = 3'd3,
        XF_TRAP = 3'd4
    } xfer_kind_t;

    // Comparison a conditional branch performs
    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_GTS = 3'd2,
        CMP_GES = 3'd3,
        CMP_GTU = 3'd4,
        CMP_GEU = 3'd5
    } cmp_op_t;

    // Decoded control record handed from the decoder to the top
    typedef struct packed {
        xfer_kind_t kind;
        cmp_op_t    cmp;
        logic       link;
        logic       is_eret;
        logic       is_bret;
        logic       is_brk;
        logic       is_scall;
    } xfer_dec_t;

endpackage

// File: rtl/bnpc_decode.sv
// Module: bnpc_decode
// Classifies an instruction word into a transfer class, a compare operation,
// a link request and the four exception-related indications.
// Assumes: purely combinational; the register fields are already resolved to
// operand values elsewhere, so only field indices are inspected here.
module bnpc_decode
    import bnpc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ERET_REG   = 30,
    parameter int BRET_REG   = 31,
    parameter int TRAP_W     = 26,
    parameter int BRK_CODE   = 2,
    parameter int SCALL_CODE = 7
) (
    input  logic [XLEN-1:0] instr,
    output xfer_dec_t       dec
);

    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RA_LSB  = OPC_LSB - RIDX_W;

    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] ra_idx;
    logic [TRAP_W-1:0] trap_code;

    assign opc       = instr[XLEN-1:OPC_LSB];
    assign ra_idx    = instr[RA_LSB +: RIDX_W];
    assign trap_code = instr[TRAP_W-1:0];

    // Map the opcode to its transfer class and side effects
    always_comb begin
        dec          = '0;
        dec.kind     = XF_NONE;
        dec.cmp      = CMP_EQ;
        unique case (opc)
            OPC_BR_EQ:  begin dec.kind = XF_COND; dec.cmp = CMP_EQ;  end
            OPC_BR_NE:  begin dec.kind = XF_COND; dec.cmp = CMP_NE;  end
            OPC_BR_GTS: begin dec.kind = XF_COND; dec.cmp = CMP_GTS; end
            OPC_BR_GES: begin dec.kind = XF_COND; dec.cmp = CMP_GES; end
            OPC_BR_GTU: begin dec.kind = XF_COND; dec.cmp = CMP_GTU; end
            OPC_BR_GEU: begin dec.kind = XF_COND; dec.cmp = CMP_GEU; end
            OPC_JMP_REL: begin
                dec.kind = XF_REL;
            end
            OPC_CALL_REL: begin
                dec.kind = XF_REL;
                dec.link = 1'b1;
            end
            OPC_JMP_REG: begin
                dec.kind    = XF_REG;
                dec.is_eret = (ra_idx == RIDX_W'(ERET_REG));
                dec.is_bret = (ra_idx == RIDX_W'(BRET_REG));
            end
            OPC_CALL_REG: begin
                dec.kind = XF_REG;
                dec.link = 1'b1;
            end
            OPC_TRAP: begin
                dec.kind     = XF_TRAP;
                dec.is_brk   = (trap_code == TRAP_W'(BRK_CODE));
                dec.is_scall = (trap_code == TRAP_W'(SCALL_CODE));
            end
            default: begin
                dec.kind = XF_NONE;
            end
        endcase
    end

endmodule

// File: rtl/bnpc_compare.sv
// Module: bnpc_compare
// Evaluates the branch condition between two operands.
// Assumes: operands are two's complement for the signed comparisons.
module bnpc_compare
    import bnpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  cmp_op_t         op,
    output logic            hit
);

    logic eq_w;
    logic gts_w;
    logic gtu_w;

    // Share one equality and two magnitude comparators across all conditions
    always_comb begin
        eq_w  = (lhs == rhs);
        gts_w = ($signed(lhs) > $signed(rhs));
        gtu_w = (lhs > rhs);
    end

    // Select the requested condition
    always_comb begin
        unique case (op)
            CMP_EQ:  hit = eq_w;
            CMP_NE:  hit = !eq_w;
            CMP_GTS: hit = gts_w;
            CMP_GES: hit = gts_w || eq_w;
            CMP_GTU: hit = gtu_w;
            CMP_GEU: hit = gtu_w || eq_w;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnpc_reloff.sv
// Module: bnpc_reloff
// Adds a word offset to the PC: the offset field is shifted left by two and
// sign-extended from its top bit to the address width.
// Assumes: OFF_W + 2 <= XLEN.
module bnpc_reloff #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  target
);

    localparam int BYTE_W = OFF_W + 2;
    localparam int PAD_W  = XLEN - BYTE_W;

    logic [BYTE_W-1:0] byte_off;
    logic [XLEN-1:0]   ext_off;

    // Turn the word offset into a sign-extended byte offset
    always_comb begin
        byte_off = {off, 2'b00};
        ext_off  = {{PAD_W{byte_off[BYTE_W-1]}}, byte_off};
    end

    // Form the target address
    assign target = pc + ext_off;

endmodule

// File: rtl/bnpc_unit.sv
// Module: bnpc_unit (top)
// Resolves the next fetch address and the return-address write for each
// instruction, with one register stage on every output.
// Assumes: opnd_a/opnd_b already hold the values of the registers named by
// bits 25:21 and 20:16; exception entry and state restore happen elsewhere.
module bnpc_unit
    import bnpc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int COND_OFF_W = 16,
    parameter int REL_OFF_W  = 26,
    parameter int LINK_REG   = 29,
    parameter int ERET_REG   = 30,
    parameter int BRET_REG   = 31,
    parameter int BRK_CODE   = 2,
    parameter int SCALL_CODE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_data,
    output logic              eret_flag,
    output logic              bret_flag,
    output logic              brk_flag,
    output logic              scall_flag
);

    localparam int           INSN_BYTES = 4;
    localparam logic [XLEN-1:0] SEQ_STEP = XLEN'(INSN_BYTES);
    localparam int           NUM_OFF    = 2;

    xfer_dec_t       dec;
    logic            cond_hit;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_tgt [NUM_OFF];

    logic [XLEN-1:0] nx_pc;
    logic            nx_taken;
    logic            nx_link_we;
    logic [XLEN-1:0] nx_link_data;

    bnpc_decode #(
        .XLEN      (XLEN),
        .ERET_REG  (ERET_REG),
        .BRET_REG  (BRET_REG),
        .TRAP_W    (REL_OFF_W),
        .BRK_CODE  (BRK_CODE),
        .SCALL_CODE(SCALL_CODE)
    ) u_decode (
        .instr(instr),
        .dec  (dec)
    );

    bnpc_compare #(
        .XLEN(XLEN)
    ) u_compare (
        .lhs(opnd_a),
        .rhs(opnd_b),
        .op (dec.cmp),
        .hit(cond_hit)
    );

    // One offset adder per offset width: index 0 short, index 1 long
    for (genvar gi = 0; gi < NUM_OFF; gi++) begin : g_off
        localparam int OW = (gi == 0) ? COND_OFF_W : REL_OFF_W;
        bnpc_reloff #(
            .XLEN (XLEN),
            .OFF_W(OW)
        ) u_reloff (
            .pc    (cur_pc),
            .off   (instr[OW-1:0]),
            .target(rel_tgt[gi])
        );
    end

    // Sequential fall-through address, also the return address
    assign seq_pc = cur_pc + SEQ_STEP;

    // Choose the next address, the taken flag and the link request
    always_comb begin
        nx_pc        = seq_pc;
        nx_taken     = 1'b0;
        nx_link_we   = 1'b0;
        nx_link_data = '0;
        unique case (dec.kind)
            XF_COND: begin
                if (cond_hit) begin
                    nx_pc    = rel_tgt[0];
                    nx_taken = 1'b1;
                end
            end
            XF_REL: begin
                nx_pc    = rel_tgt[1];
                nx_taken = 1'b1;
            end
            XF_REG: begin
                nx_pc    = opnd_a;
                nx_taken = 1'b1;
            end
            default: begin
                nx_pc    = seq_pc;
                nx_taken = 1'b0;
            end
        endcase
        if (dec.link) begin
            nx_link_we   = 1'b1;
            nx_link_data = seq_pc;
        end
    end

    // Register every result; synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc    <= '0;
            taken      <= 1'b0;
            link_we    <= 1'b0;
            link_data  <= '0;
            eret_flag  <= 1'b0;
            bret_flag  <= 1'b0;
            brk_flag   <= 1'b0;
            scall_flag <= 1'b0;
        end else begin
            next_pc    <= nx_pc;
            taken      <= nx_taken;
            link_we    <= nx_link_we;
            link_data  <= nx_link_data;
            eret_flag  <= dec.is_eret;
            bret_flag  <= dec.is_bret;
            brk_flag   <= dec.is_brk;
            scall_flag <= dec.is_scall;
        end
    end

    // Return-address register index is fixed
    assign link_idx = RIDX_W'(LINK_REG);

endmodule

// File: rtl/bnpc_unit_chk.sv
// Module: bnpc_unit_chk
// Temporal checks on the registered outputs of bnpc_unit against the inputs
// seen one edge earlier. Attached through bind below.
module bnpc_unit_chk #(
    parameter int XLEN     = 32,
    parameter int LINK_REG = 29
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] cur_pc,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] next_pc,
    input logic            taken,
    input logic            link_we,
    input logic [4:0]      link_idx,
    input logic [XLEN-1:0] link_data,
    input logic            eret_flag,
    input logic            bret_flag,
    input logic            brk_flag,
    input logic            scall_flag
);

    // R2
    seq_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && $past(rst_n)) |-> (next_pc == $past(cur_pc) + XLEN'(4)));

    // R6
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (taken && link_data == $past(cur_pc) + XLEN'(4)));

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eret_flag, bret_flag, brk_flag, scall_flag}));

    // R8
    trap_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag || scall_flag) |-> (!taken && !link_we));

    // R7
    ret_to_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_flag || bret_flag) |-> (taken && next_pc == $past(opnd_a)));

    // R10
    link_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_idx == 5'(LINK_REG));

endmodule

bind bnpc_unit bnpc_unit_chk #(
    .XLEN    (XLEN),
    .LINK_REG(LINK_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_pc    (cur_pc),
    .opnd_a    (opnd_a),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .link_data (link_data),
    .eret_flag (eret_flag),
    .bret_flag (bret_flag),
    .brk_flag  (brk_flag),
    .scall_flag(scall_flag)
);

// File: tb/bnpc_unit_bench.sv
module bnpc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] instr = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;
    logic        eret_flag, bret_flag, brk_flag, scall_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bnpc_unit u_bnpc_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .next_pc(next_pc), .taken(taken),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
        .eret_flag(eret_flag), .bret_flag(bret_flag), .brk_flag(brk_flag),
        .scall_flag(scall_flag)
    );

    // Instruction builders
    function automatic logic [31:0] mk_cond(int op, int ra, int rb, int off);
        return {6'(op), 5'(ra), 5'(rb), 16'(off)};
    endfunction
    function automatic logic [31:0] mk_long(int op, int field);
        return {6'(op), 26'(field)};
    endfunction
    function automatic logic [31:0] mk_reg(int op, int ra);
        return {6'(op), 5'(ra), 21'd0};
    endfunction

    // Reference model: expected outputs from the requirement text
    task automatic ref_model(input logic [31:0] pc, ins, a, b,
                             output logic [31:0] e_pc, output logic e_tk,
                             output logic e_lw, output logic [31:0] e_ld,
                             output logic [3:0] e_fl);
        int op, ra, code, sa, sb, o16, o26;
        longint ua, ub;
        bit cond;
        op = int'(ins[31:26]); ra = int'(ins[25:21]); code = int'(ins[25:0]);
        sa = int'($signed(a)); sb = int'($signed(b));
        ua = longint'(a); ub = longint'(b);
        o16 = int'(ins[15:0]); if (o16 >= 32768) o16 -= 65536;
        o26 = code; if (o26 >= (1 << 25)) o26 -= (1 << 26);
        e_pc = pc + 32'd4; e_tk = 0; e_lw = 0; e_ld = 0; e_fl = 4'b0000;
        cond = 0;
        case (op)
            17: cond = (a == b);
            23: cond = (a != b);
            18: cond = (sa > sb);
            19: cond = (sa >= sb);
            21: cond = (ua > ub);
            20: cond = (ua >= ub);
            default: cond = 0;
        endcase
        if (op inside {17, 18, 19, 20, 21, 23} && cond) begin
            e_tk = 1; e_pc = pc + 32'(o16 * 4);
        end
        if (op == 56 || op == 62) begin
            e_tk = 1; e_pc = pc + 32'(o26 * 4);
        end
        if (op == 48 || op == 54) begin
            e_tk = 1; e_pc = a;
        end
        if (op == 62 || op == 54) begin
            e_lw = 1; e_ld = pc + 32'd4;
        end
        if (op == 48 && ra == 30) e_fl = 4'b1000;
        if (op == 48 && ra == 31) e_fl = 4'b0100;
        if (op == 43 && code == 2) e_fl = 4'b0010;
        if (op == 43 && code == 7) e_fl = 4'b0001;
    endtask

    // Compare all outputs with expected values
    task automatic compare(string tag, logic [31:0] e_pc, logic e_tk,
                           logic e_lw, logic [31:0] e_ld, logic [3:0] e_fl);
        logic [3:0] fl;
        fl = {eret_flag, bret_flag, brk_flag, scall_flag};
        checks++;
        if (next_pc !== e_pc || taken !== e_tk || link_we !== e_lw ||
            link_data !== e_ld || fl !== e_fl || link_idx !== 5'd29) begin
            errors++;
            $display("FAIL %s: got pc=%h tk=%b lw=%b ld=%h fl=%b idx=%0d exp pc=%h tk=%b lw=%b ld=%h fl=%b idx=29",
                     tag, next_pc, taken, link_we, link_data, fl, link_idx,
                     e_pc, e_tk, e_lw, e_ld, e_fl);
        end
    endtask

    // Drive one instruction, wait one edge, compare against the model
    task automatic apply(string tag, logic [31:0] pc, ins, a, b);
        logic [31:0] e_pc, e_ld;
        logic e_tk, e_lw;
        logic [3:0] e_fl;
        @(negedge clk);
        cur_pc = pc; instr = ins; opnd_a = a; opnd_b = b;
        ref_model(pc, ins, a, b, e_pc, e_tk, e_lw, e_ld, e_fl);
        @(posedge clk);
        #1;
        compare(tag, e_pc, e_tk, e_lw, e_ld, e_fl);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got no completion exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset clears outputs while a call is presented
        rst_n = 0;
        cur_pc = 32'h0000_2000; instr = mk_reg(54, 7); opnd_a = 32'hDEAD_BEEF;
        repeat (2) @(posedge clk);
        #1;
        compare("R11 reset", 32'd0, 1'b0, 1'b0, 32'd0, 4'b0000);
        @(negedge clk); rst_n = 1;

        // R1 / R2: conditional branches
        apply("R1 eq taken",        32'h1000, mk_cond(17, 1, 2, 3),      32'd5, 32'd5);
        apply("R2 eq not taken",    32'h1000, mk_cond(17, 1, 2, 3),      32'd5, 32'd6);
        apply("R2 gts signed",      32'h1000, mk_cond(18, 1, 2, 16'hFFFF), 32'hFFFF_FFFF, 32'd1);
        apply("R1 gtu unsigned",    32'h1000, mk_cond(21, 1, 2, 16'hFFFF), 32'hFFFF_FFFF, 32'd1);
        apply("R1 ges equal",       32'h1000, mk_cond(19, 1, 2, 16'h8000), 32'h8000_0000, 32'h8000_0000);
        apply("R1 ges signed",      32'h8000, mk_cond(19, 1, 2, 16'h7FFF), 32'd1, 32'hFFFF_FFFE);
        apply("R2 geu below",       32'h1000, mk_cond(20, 1, 2, 4),       32'd1, 32'hFFFF_FFFE);
        apply("R1 geu equal",       32'h1000, mk_cond(20, 1, 2, 4),       32'd9, 32'd9);
        apply("R2 gtu equal",       32'h1000, mk_cond(21, 1, 2, 4),       32'd9, 32'd9);
        apply("R1 ne taken",        32'h1000, mk_cond(23, 1, 2, 16'hFFFE), 32'd1, 32'd2);
        apply("R2 ne equal",        32'h1000, mk_cond(23, 1, 2, 16'hFFFE), 32'd2, 32'd2);
        // R3 / R4: long relative transfers
        apply("R3 rel jump fwd",    32'h4000, mk_long(56, 32'h100),     32'd0, 32'd0);
        apply("R3 rel jump -1",     32'h4000, mk_long(56, 32'h3FF_FFFF), 32'd0, 32'd0);
        apply("R3 rel jump min",    32'h1000_0000, mk_long(56, 32'h200_0000), 32'd0, 32'd0);
        apply("R4 rel call",        32'h4000, mk_long(62, 32'h20),      32'd0, 32'd0);
        // R5 / R6 / R7: register transfers
        apply("R5 reg jump",        32'h5000, mk_reg(48, 5),  32'h0001_2344, 32'd0);
        apply("R6 reg call",        32'h5000, mk_reg(54, 5),  32'h0003_0000, 32'd0);
        apply("R7 plain return",    32'h5000, mk_reg(48, 29), 32'h0000_0ABC, 32'd0);
        apply("R7 eret",            32'h5000, mk_reg(48, 30), 32'h0000_0100, 32'd0);
        apply("R7 bret",            32'h5000, mk_reg(48, 31), 32'h0000_0200, 32'd0);
        apply("R7 call r30 no flag", 32'h5000, mk_reg(54, 30), 32'h0000_0300, 32'd0);
        // R8: traps
        apply("R8 break",           32'h6000, mk_long(43, 2), 32'd0, 32'd0);
        apply("R8 syscall",         32'h6000, mk_long(43, 7), 32'd0, 32'd0);
        apply("R8 other code",      32'h6000, mk_long(43, 3), 32'd0, 32'd0);
        // R9 / R10: non-control opcodes
        apply("R9 add opcode",      32'h7000, mk_cond(45, 29, 30, 16'h1234), 32'd1, 32'd2);
        apply("R10 no link",        32'hFFFF_FFFC, mk_cond(13, 0, 0, 0), 32'd0, 32'd0);
        apply("R4 call wrap",       32'hFFFF_FFFC, mk_long(62, 1), 32'd0, 32'd0);

        // R11: reset in mid-stream
        @(negedge clk); rst_n = 0; instr = mk_long(43, 7);
        @(posedge clk); #1;
        compare("R11 mid reset", 32'd0, 1'b0, 1'b0, 32'd0, 4'b0000);
        @(negedge clk); rst_n = 1;
        apply("R11 after reset",    32'h0000_0040, mk_cond(17, 1, 2, 1), 32'd0, 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule